// File: doc/BRIEF.md
# Truth-Table Trigger Evaluator

This block decides, sample by sample, whether a 16-channel logic stream meets a programmable trigger condition. The channels are grouped into quads. Each quad's four bits address a 16-entry truth table, and a match term is true when all of its quad tables return one. Three match terms are formed this way. One is a plain level qualifier. The other two are edge sources, whose current and previous states feed a final glue lookup that turns level matches into rise, fall or level detection.

Software or a sequencer loads all tables through a narrow configuration port. Each write sets one bit position of every table at once. An arm pulse starts a fresh capture. The registered trigger output pulses one cycle after each qualifying sample.

Top module: `lut_trig_eval`

## Requirements
- R1: After reset every table holds zero and `trigger` is low, so no sample can fire the trigger until tables are loaded.
- R2: Quad q is addressed by `sample[4q+3:4q]`, with `sample[4q]` as index bit 0. A match term is one only when all of its quad tables return one at their index.
- R3: A cycle with `cfgValid` high writes bit `cfgIndex` of every table from `cfgWord`. Bits 3:0 go to the quads 0..3 of edge source 0, bits 7:4 to the quads of edge source 1, bits 11:8 to the quads of the level qualifier, bit 12 to glue table A and bit 13 to glue table B.
- R4: The glue index is {cur1, prev1, cur0, prev0}, with prev0 at bit 0, where curN and prevN are the current and previous states of edge source N. The glue result is glue A OR glue B at that index.
- R5: `trigger` is registered. It is high in the cycle after a sample with `sampleValid` high only when the glue result AND the level qualifier are both one for that sample. It is low after any cycle without a sample.
- R6: The previous states of the edge sources change only on accepted samples. Idle cycles between samples do not disturb edge detection.
- R7: `armPulse` clears `trigger` on the next cycle. The first sample accepted after arming uses its own state as the previous state, so no edge is seen on it. A sample presented in the same cycle as `armPulse` is dropped.
- R8: Bits 15:14 of `cfgWord` have no effect on any table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Table write strobe |
| cfgIndex | input | 4 | Table bit position written |
| cfgWord | input | 16 | One bit per table for that position |
| armPulse | input | 1 | Start of a new capture |
| sampleValid | input | 1 | Sample present this cycle |
| sample | input | 16 | Channel values |
| trigger | output | 1 | Registered trigger pulse |

## Verification
The bench builds the block with its default of four quads, so all sixteen channels and every word bit up to the glue tables are exercised. Tables are derived in the bench from value/mask pairs for rise on source 0, fall on source 1, a level on source 0 and a top-quad qualifier. With these tables the bench checks edges across idle gaps, the first sample after arming, arm colliding with a sample, and writes that carry the ignored high word bits.

// File: rtl/lut_trig_pkg.sv
package lut_trig_pkg;
  localparam int TBL_IDX_W = 4;
  localparam int TBL_DEPTH = 1 << TBL_IDX_W;

  typedef struct packed {
    logic loadEn;
    logic sampleEn;
    logic armClr;
    logic firstSample;
  } trigStrobes_t;
endpackage

// File: rtl/lut_trig_ctrl.sv
module lut_trig_ctrl
  import lut_trig_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgValid,
  input  logic         armPulse,
  input  logic         sampleValid,
  output trigStrobes_t strobes
);
  logic firstReg;

  always_ff @(posedge clk) begin
    if (!rstN)
      firstReg <= 1'b1;
    else if (armPulse)
      firstReg <= 1'b1;
    else if (sampleValid)
      firstReg <= 1'b0;
  end

  always_comb begin
    strobes.loadEn      = cfgValid;
    strobes.armClr      = armPulse;
    strobes.sampleEn    = sampleValid & ~armPulse;
    strobes.firstSample = firstReg;
  end

  // R7: arming marks the next accepted sample as the first one
  p_arm_sets_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    armPulse |=> strobes.firstSample);

  // R7: an accepted sample ends the first-sample window
  p_sample_ends_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !armPulse) |=> !strobes.firstSample);
endmodule

// File: rtl/lut_trig_datapath.sv
module lut_trig_datapath
  import lut_trig_pkg::*;
#(
  parameter int QUADS = 4,
  localparam int CHANNELS = 4 * QUADS,
  localparam int CFG_W = 4 * QUADS
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  trigStrobes_t         strobes,
  input  logic [TBL_IDX_W-1:0] cfgIndex,
  input  logic [CFG_W-1:0]     cfgWord,
  input  logic [CHANNELS-1:0]  sample,
  output logic                 trigger
);
  localparam int SRC1_LO = QUADS;
  localparam int VAL_LO  = 2 * QUADS;
  localparam int GLUE_A  = 3 * QUADS;
  localparam int GLUE_B  = 3 * QUADS + 1;

  logic [QUADS-1:0][TBL_DEPTH-1:0] src0Tbl, src1Tbl, valTbl;
  logic [TBL_DEPTH-1:0] glueA, glueB;
  logic [QUADS-1:0] hit0, hit1, hitV;
  logic curM0, curM1, curMv;
  logic prevM0, prevM1;
  logic effPrev0, effPrev1;
  logic [TBL_IDX_W-1:0] glueIdx;
  logic glueHit;

  // table storage: one bit position of every table per write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      src0Tbl <= '0;
      src1Tbl <= '0;
      valTbl  <= '0;
      glueA   <= '0;
      glueB   <= '0;
    end else if (strobes.loadEn) begin
      for (int q = 0; q < QUADS; q++) begin
        src0Tbl[q][cfgIndex] <= cfgWord[q];
        src1Tbl[q][cfgIndex] <= cfgWord[SRC1_LO + q];
        valTbl[q][cfgIndex]  <= cfgWord[VAL_LO + q];
      end
      glueA[cfgIndex] <= cfgWord[GLUE_A];
      glueB[cfgIndex] <= cfgWord[GLUE_B];
    end
  end

  // quad lookups
  for (genvar q = 0; q < QUADS; q++) begin : g_quad
    logic [TBL_IDX_W-1:0] quadIdx;
    assign quadIdx = sample[4*q +: 4];
    assign hit0[q] = src0Tbl[q][quadIdx];
    assign hit1[q] = src1Tbl[q][quadIdx];
    assign hitV[q] = valTbl[q][quadIdx];
  end

  assign curM0 = &hit0;
  assign curM1 = &hit1;
  assign curMv = &hitV;

  // edge history
  always_ff @(posedge clk) begin
    if (!rstN || strobes.armClr) begin
      prevM0 <= 1'b0;
      prevM1 <= 1'b0;
    end else if (strobes.sampleEn) begin
      prevM0 <= curM0;
      prevM1 <= curM1;
    end
  end

  assign effPrev0 = strobes.firstSample ? curM0 : prevM0;
  assign effPrev1 = strobes.firstSample ? curM1 : prevM1;
  assign glueIdx  = {curM1, effPrev1, curM0, effPrev0};
  assign glueHit  = glueA[glueIdx] | glueB[glueIdx];

  always_ff @(posedge clk) begin
    if (!rstN || strobes.armClr)
      trigger <= 1'b0;
    else
      trigger <= strobes.sampleEn & glueHit & curMv;
  end

  // R5: a pulse always follows an accepted sample
  p_trig_after_sample_r5: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> $past(strobes.sampleEn));

  // R5: a pulse requires the level qualifier on that sample
  p_trig_needs_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> $past(curMv));

  // R6: history holds across idle cycles
  p_prev_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.sampleEn && !strobes.armClr) |=> ($stable(prevM0) && $stable(prevM1)));

  // R7: arming silences the output on the next cycle
  p_arm_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.armClr |=> !trigger);
endmodule

// File: rtl/lut_trig_eval.sv
module lut_trig_eval
  import lut_trig_pkg::*;
#(
  parameter int QUADS = 4,
  localparam int CHANNELS = 4 * QUADS,
  localparam int CFG_W = 4 * QUADS
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgValid,
  input  logic [TBL_IDX_W-1:0] cfgIndex,
  input  logic [CFG_W-1:0]     cfgWord,
  input  logic                 armPulse,
  input  logic                 sampleValid,
  input  logic [CHANNELS-1:0]  sample,
  output logic                 trigger
);
  trigStrobes_t strobes;

  lut_trig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid),
    .armPulse(armPulse), .sampleValid(sampleValid), .strobes(strobes)
  );

  lut_trig_datapath #(.QUADS(QUADS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgIndex(cfgIndex),
    .cfgWord(cfgWord), .sample(sample), .trigger(trigger)
  );
endmodule

// File: tb/lut_trig_eval_tb.sv
`timescale 1ns/1ps
module lut_trig_eval_tb;
  localparam real CLK_NS = 20.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgValid = 1'b0;
  logic [3:0] cfgIndex = '0;
  logic [15:0] cfgWord = '0;
  logic armPulse = 1'b0;
  logic sampleValid = 1'b0;
  logic [15:0] sample = '0;
  logic trigger;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  lut_trig_eval u_dut (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgIndex(cfgIndex),
    .cfgWord(cfgWord), .armPulse(armPulse), .sampleValid(sampleValid),
    .sample(sample), .trigger(trigger)
  );

  // config A, source-0 rise on ch5 qualified by ch0 high: {expected, sample}
  localparam logic [16:0] VEC_A [11] = '{
    {1'b0, 16'h0021}, {1'b0, 16'h0000}, {1'b0, 16'h0020}, {1'b0, 16'h0000},
    {1'b1, 16'h0021}, {1'b0, 16'h0021}, {1'b0, 16'h0001}, {1'b1, 16'hFFFF},
    {1'b0, 16'h0000}, {1'b0, 16'h0020}, {1'b0, 16'h0021}
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: trigger=%b expected=%b", req, act, exp);
    end
  endtask

  // truth table for one quad from a value/mask pair
  function automatic logic [15:0] quadTbl(input logic [15:0] val,
                                          input logic [15:0] msk, input int q);
    logic [15:0] t = '1;
    for (int j = 0; j < 16; j++)
      for (int k = 0; k < 4; k++)
        if (msk[4*q+k] && (val[4*q+k] != j[k])) t[j] = 1'b0;
    return t;
  endfunction

  task automatic loadConfig(input logic [15:0] vV, input logic [15:0] vM,
                            input logic [15:0] aV, input logic [15:0] aM,
                            input logic [15:0] bV, input logic [15:0] bM,
                            input logic [15:0] gA, input logic [15:0] gB,
                            input logic [1:0] extra);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] w = '0;
      for (int q = 0; q < 4; q++) begin
        w[q]     = quadTbl(aV, aM, q)[i];
        w[4 + q] = quadTbl(bV, bM, q)[i];
        w[8 + q] = quadTbl(vV, vM, q)[i];
      end
      w[12] = gA[i];
      w[13] = gB[i];
      w[15:14] = extra;
      cfgValid = 1'b1; cfgIndex = 4'(i); cfgWord = w;
      @(negedge clk);
    end
    cfgValid = 1'b0;
  endtask

  task automatic arm();
    armPulse = 1'b1;
    @(negedge clk);
    armPulse = 1'b0;
    check(trigger, 1'b0, "R7 arm clears");
  endtask

  task automatic feed(input logic [15:0] s, input logic exp, input string req);
    sampleValid = 1'b1; sample = s;
    @(negedge clk);
    sampleValid = 1'b0;
    check(trigger, exp, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(trigger, 1'b0, "R5 idle low");
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(trigger, 1'b0, "R1 reset low");
    feed(16'hFFFF, 1'b0, "R1 empty tables");
    feed(16'h0000, 1'b0, "R1 empty tables");

    // R3 R4: rise on source 0 (glue A prev0=0,cur0=1), source 1 unmasked
    loadConfig(16'h0001, 16'h0001, 16'h0020, 16'h0020, 16'h0, 16'h0,
               16'h4444, 16'h0000, 2'b00);
    arm();
    foreach (VEC_A[i]) feed(VEC_A[i][15:0], VEC_A[i][16], "R4 rise vector");

    // R4 R6: fall on source 1 via glue B, history held over idle
    loadConfig(16'h0, 16'h0, 16'h0, 16'h0, 16'h1000, 16'h1000,
               16'h0000, 16'h00F0, 2'b00);
    arm();
    feed(16'h1000, 1'b0, "R7 first sample no edge");
    feed(16'h0000, 1'b1, "R4 fall source 1");
    feed(16'h0000, 1'b0, "R4 fall once");
    feed(16'h1000, 1'b0, "R4 rise not fall");
    idle(3);
    feed(16'h0000, 1'b1, "R6 fall across idle");

    // R7: sample with arm is dropped
    armPulse = 1'b1; sampleValid = 1'b1; sample = 16'h1000;
    @(negedge clk);
    armPulse = 1'b0; sampleValid = 1'b0;
    check(trigger, 1'b0, "R7 arm priority");
    feed(16'h0000, 1'b0, "R7 dropped sample");
    feed(16'h1000, 1'b0, "R7 rise after arm");
    feed(16'h0000, 1'b1, "R7 fall after arm");

    // R4: level on source 0 (ch3 low), fires on first sample
    loadConfig(16'h0, 16'h0, 16'h0000, 16'h0008, 16'h0, 16'h0,
               16'hCCCC, 16'h0000, 2'b00);
    arm();
    feed(16'h0000, 1'b1, "R4 level first");
    feed(16'h0008, 1'b0, "R4 level miss");
    feed(16'h0000, 1'b1, "R4 level again");

    // R8: same tables, ignored word bits set
    loadConfig(16'h0, 16'h0, 16'h0000, 16'h0008, 16'h0, 16'h0,
               16'hCCCC, 16'h0000, 2'b11);
    arm();
    feed(16'h0000, 1'b1, "R8 ignored bits");
    feed(16'h0008, 1'b0, "R8 ignored bits");

    // R2: qualifier on top quad, ch15=1 ch14=0, glue A all ones
    loadConfig(16'h8000, 16'hC000, 16'h0, 16'h0, 16'h0, 16'h0,
               16'hFFFF, 16'h0000, 2'b00);
    arm();
    feed(16'h8000, 1'b1, "R2 quad 3 hit");
    feed(16'h4000, 1'b0, "R2 quad 3 miss");
    feed(16'hC000, 1'b0, "R2 quad 3 ch14");
    feed(16'h8FFF, 1'b1, "R2 other quads free");
    idle(1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule